// File: doc/BRIEF.md
# Per-Tube Multiplicity Lookup Unit

This block turns one detector tube's per-crossing measurement into a small hit-multiplicity code. On every clock cycle, which is one bunch crossing, it takes an 8-bit integrated amplitude and a 4-bit arrival-time code. It joins them into a 12-bit table address and reads a 3-bit multiplicity from a loadable table. The result goes straight to the trigger port two cycles later.

The same result also enters a fixed-length delay line. When a level-1 accept pulse arrives, the entry that left the lookup exactly `PIPE_DEPTH` crossings earlier is captured. It is pushed into a small readout FIFO together with the crossing number it belongs to. The FIFO drains through a valid/ready port. While `rd_valid` is high and `rd_ready` is low, the head entry and `rd_valid` hold steady. An entry leaves on a cycle where both are high. When the FIFO is full the block raises `busy`. Accepts that arrive in that state are lost and counted. A downstream stall therefore never stalls the lookup or the delay line: back-pressure ends at the FIFO.

The table has no reset. It is filled through a one-entry-per-cycle write port, and writes may go on while lookups are running.

Top module: `tube_mult_lut`

## Requirements
- R1: The lookup address is `{amp, toa}`, with amplitude in bits 11:4 and time in bits 3:0. The input presented in cycle n shows as `trig_mult` = table[address] in cycle n+2. `trig_valid` is low in cycles 0 and 1 after reset release and high from cycle 2 onward.
- R2: A table write (`tbl_we`, `tbl_addr`, `tbl_wdata`) presented in the same cycle as a lookup of the same address does not affect that lookup, which returns the previous contents. Every lookup presented in a later cycle returns the new value.
- R3: A crossing counter is 0 in cycle 0 after reset release, counts up by one each cycle and wraps from `ORBIT_LEN-1` to 0. Every read-out entry carries in `rd_bcid` the counter value of the cycle whose `trig_mult` it holds, which is always below `ORBIT_LEN`.
- R4: An accept in cycle n, with n >= `PIPE_DEPTH`+2, captures the `trig_mult` value of cycle n-`PIPE_DEPTH`. If the FIFO is not full, the entry is appended to the FIFO.
- R5: An accept in a cycle n < `PIPE_DEPTH`+2 finds no valid entry in the delay line. It is ignored: nothing enters the FIFO and nothing is counted.
- R6: The FIFO delivers entries in capture order. `rd_valid` is high exactly when it holds at least one entry. An entry is removed only on a cycle with `rd_valid` and `rd_ready` both high. While `rd_ready` is low, `rd_valid`, `rd_mult` and `rd_bcid` hold.
- R7: `busy` is high exactly when the FIFO holds `FIFO_DEPTH` entries. A valid accept that arrives while `busy` is high is dropped and increments `drop_cnt` (which saturates). This holds even if an entry leaves in the same cycle.
- R8: During and directly after reset, `trig_valid`, `rd_valid` and `busy` are low and `drop_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock, one cycle per bunch crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp | input | 8 | Digitized integrated amplitude for this crossing |
| toa | input | 4 | Arrival-time code for this crossing |
| trig_valid | output | 1 | `trig_mult` carries a lookup result |
| trig_mult | output | 3 | Multiplicity code to the trigger unit |
| l1_accept | input | 1 | Level-1 accept pulse, one cycle per accept |
| rd_valid | output | 1 | Readout FIFO head is valid |
| rd_ready | input | 1 | Consumer takes the head entry this cycle |
| rd_mult | output | 3 | Multiplicity of the head entry |
| rd_bcid | output | 12 | Crossing number of the head entry |
| busy | output | 1 | Readout FIFO is full; accepts are being dropped |
| drop_cnt | output | 16 | Saturating count of dropped accepts |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 12 | Table write address, same layout as the lookup address |
| tbl_wdata | input | 3 | Table write data |

## Verification
The assertions take for granted that every input carries a defined 0 or 1 from reset release onward. They also assume that `l1_accept` and `rd_ready` are the only causes of change in the FIFO and drop counter, and that `ORBIT_LEN` fits in the 12-bit crossing number. The stimulus drives every input once per cycle on the falling clock edge, starting before reset is released. It holds the inputs steady through reset, so no property ever samples an undriven pin. Accepts are only issued where the bench knows what the addressed entry should contain, apart from the deliberate early accepts that must be ignored.

// File: rtl/tml_pkg.sv
package tml_pkg;
  localparam int MULT_W = 3;
  localparam int BCID_W = 12;

  typedef struct packed {
    logic [BCID_W-1:0] bcid;
    logic [MULT_W-1:0] mult;
  } rd_entry_t;
endpackage

// File: rtl/tml_lut.sv
// Loadable lookup table: one register stage on address and write port,
// one synchronous read stage. Writes land on the same edge as the read
// of a lookup presented in the same cycle, so that read sees old data.
module tml_lut #(
  parameter int AMP_W  = 8,
  parameter int TOA_W  = 4,
  parameter int MULT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AMP_W-1:0]        amp,
  input  logic [TOA_W-1:0]        toa,
  input  logic                    wr_en,
  input  logic [AMP_W+TOA_W-1:0]  wr_addr,
  input  logic [MULT_W-1:0]       wr_data,
  output logic                    res_valid,
  output logic [MULT_W-1:0]       res_mult
);
  localparam int ADDR_W  = AMP_W + TOA_W;
  localparam int ENTRIES = 1 << ADDR_W;

  logic [MULT_W-1:0] table_q [ENTRIES];
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [MULT_W-1:0] wr_data_q;
  logic              wr_en_q;
  logic [1:0]        vld_q;
  logic [MULT_W-1:0] mult_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
      vld_q   <= '0;
    end else begin
      wr_en_q <= wr_en;
      vld_q   <= {vld_q[0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    rd_addr_q <= {amp, toa};
    wr_addr_q <= wr_addr;
    wr_data_q <= wr_data;
    mult_q    <= table_q[rd_addr_q];
    if (wr_en_q) table_q[wr_addr_q] <= wr_data_q;
  end

  assign res_valid = vld_q[1];
  assign res_mult  = mult_q;
endmodule

// File: rtl/tml_delay.sv
// Circular delay line: the slot under the write pointer still holds the
// value written DEPTH cycles ago until the next edge overwrites it.
module tml_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q;
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (in_valid && fill_q != CW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    slot_q[wp_q] <= in_data;
  end

  assign out_valid = (fill_q == CW'(DEPTH));
  assign out_data  = slot_q[wp_q];
endmodule

// File: rtl/tml_fifo.sv
module tml_fifo
  import tml_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rd_entry_t din,
  input  logic      pop,
  output logic      full,
  output logic      empty,
  output rd_entry_t dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rd_entry_t     mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rp_q];
endmodule

// File: rtl/tube_mult_lut.sv
module tube_mult_lut
  import tml_pkg::*;
#(
  parameter int AMP_W      = 8,
  parameter int TOA_W      = 4,
  parameter int PIPE_DEPTH = 128,
  parameter int FIFO_DEPTH = 16,
  parameter int ORBIT_LEN  = 3564,
  parameter int DROP_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AMP_W-1:0]       amp,
  input  logic [TOA_W-1:0]       toa,
  output logic                   trig_valid,
  output logic [MULT_W-1:0]      trig_mult,
  input  logic                   l1_accept,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [MULT_W-1:0]      rd_mult,
  output logic [BCID_W-1:0]      rd_bcid,
  output logic                   busy,
  output logic [DROP_W-1:0]      drop_cnt,
  input  logic                   tbl_we,
  input  logic [AMP_W+TOA_W-1:0] tbl_addr,
  input  logic [MULT_W-1:0]      tbl_wdata
);
  localparam int BACK = ORBIT_LEN - (PIPE_DEPTH % ORBIT_LEN);
  localparam int SW   = BCID_W + 1;

  logic              lut_valid;
  logic [MULT_W-1:0] lut_mult;
  logic              dly_valid;
  logic [MULT_W-1:0] dly_mult;
  logic [BCID_W-1:0] bc_q;
  logic [SW-1:0]     bc_sum;
  logic [BCID_W-1:0] cap_bc;
  logic              take, push, pop, fifo_full, fifo_empty;
  rd_entry_t         push_ent, head_ent;

  tml_lut #(.AMP_W(AMP_W), .TOA_W(TOA_W), .MULT_W(MULT_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .amp(amp), .toa(toa),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .res_valid(lut_valid), .res_mult(lut_mult)
  );

  tml_delay #(.W(MULT_W), .DEPTH(PIPE_DEPTH)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_valid(lut_valid), .in_data(lut_mult),
    .out_valid(dly_valid), .out_data(dly_mult)
  );

  // Crossing counter; the id of the delayed entry is derived, not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc_q <= '0;
    else        bc_q <= (bc_q == BCID_W'(ORBIT_LEN - 1)) ? '0 : bc_q + 1'b1;
  end

  always_comb begin
    bc_sum = {1'b0, bc_q} + SW'(BACK);
    cap_bc = (bc_sum >= SW'(ORBIT_LEN)) ? BCID_W'(bc_sum - SW'(ORBIT_LEN))
                                        : BCID_W'(bc_sum);
  end

  assign take          = l1_accept && dly_valid;
  assign push          = take && !fifo_full;
  assign pop           = rd_valid && rd_ready;
  assign push_ent.bcid = cap_bc;
  assign push_ent.mult = dly_mult;

  tml_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_ent), .pop(pop),
    .full(fifo_full), .empty(fifo_empty), .dout(head_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_cnt <= '0;
    else if (take && fifo_full && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
  end

  assign trig_valid = lut_valid;
  assign trig_mult  = lut_mult;
  assign rd_valid   = !fifo_empty;
  assign rd_mult    = head_ent.mult;
  assign rd_bcid    = head_ent.bcid;
  assign busy       = fifo_full;
endmodule

// File: rtl/tube_mult_lut_chk.sv
module tube_mult_lut_chk #(
  parameter int ORBIT_LEN = 3564,
  parameter int BCID_W    = 12,
  parameter int MULT_W    = 3,
  parameter int DROP_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_valid,
  input logic              l1_accept,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [MULT_W-1:0] rd_mult,
  input logic [BCID_W-1:0] rd_bcid,
  input logic              busy,
  input logic [DROP_W-1:0] drop_cnt
);
  AST_TRIG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> trig_valid); // R1
  AST_BCID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_bcid < BCID_W'(ORBIT_LEN))); // R3
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(l1_accept)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_mult) && $stable(rd_bcid))); // R6
  AST_BUSY_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_valid); // R7
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_cnt) |-> ($past(l1_accept) && $past(busy))); // R7
endmodule

bind tube_mult_lut tube_mult_lut_chk #(
  .ORBIT_LEN(ORBIT_LEN), .BCID_W(tml_pkg::BCID_W),
  .MULT_W(tml_pkg::MULT_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .l1_accept(l1_accept),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_mult(rd_mult),
  .rd_bcid(rd_bcid), .busy(busy), .drop_cnt(drop_cnt)
);

// File: tb/tube_mult_lut_tb.sv
module tube_mult_lut_tb;
  localparam int CLK_P = 10;
  localparam int PD    = 128;
  localparam int FD    = 16;
  localparam int ORB   = 3564;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  amp = '0;
  logic [3:0]  toa = '0;
  logic        trig_valid;
  logic [2:0]  trig_mult;
  logic        l1_accept = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [2:0]  rd_mult;
  logic [11:0] rd_bcid;
  logic        busy;
  logic [15:0] drop_cnt;
  logic        tbl_we = 1'b0;
  logic [11:0] tbl_addr = '0;
  logic [2:0]  tbl_wdata = '0;

  always #(CLK_P/2) clk = ~clk;

  tube_mult_lut u_dut (
    .clk(clk), .rst_n(rst_n), .amp(amp), .toa(toa),
    .trig_valid(trig_valid), .trig_mult(trig_mult), .l1_accept(l1_accept),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_mult(rd_mult), .rd_bcid(rd_bcid),
    .busy(busy), .drop_cnt(drop_cnt), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata)
  );

  int checks = 0;
  int failures = 0;
  int n = 0;
  int occ = 0;
  int edrop = 0;
  logic [2:0] model [4096];
  bit         known [4096];
  logic [2:0] texp [512];
  bit         tkn [512];
  bit         tcol [512];
  logic [14:0] sbq [$];   // {bcid, mult}

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic logic [2:0] pat(input int a);
    return 3'((a * 5 + (a >> 4) + (a >> 9)) & 7);
  endfunction

  // Driver: checks per-cycle outputs, drives one crossing, updates models.
  task automatic step(input int a, input int t, input bit we, input int wa,
                      input int wd, input bit acc, input bit rdy, input bit col);
    int ad, k, push, pop;
    if (tkn[n % 512])
      chk(trig_mult == texp[n % 512], tcol[n % 512] ? "R2" : "R1",
          trig_mult, texp[n % 512]);
    chk(trig_valid == (n >= 2), "R1", trig_valid, n >= 2);
    chk(busy == (occ == FD), "R7", busy, occ == FD);
    chk(drop_cnt == 16'(edrop), "R7", drop_cnt, edrop);
    chk(rd_valid == (occ != 0), "R6", rd_valid, occ != 0);
    if (n == PD + 2) chk(rd_valid == 1'b0, "R5", rd_valid, 0);

    amp = 8'(a); toa = 4'(t); tbl_we = we; tbl_addr = 12'(wa);
    tbl_wdata = 3'(wd); l1_accept = acc; rd_ready = rdy;

    ad = (a << 4) | t;
    texp[(n + 2) % 512] = model[ad];
    tkn[(n + 2) % 512]  = known[ad];
    tcol[(n + 2) % 512] = col;
    push = 0;
    if (acc && n >= PD + 2) begin
      k = n - PD;
      if (occ == FD) edrop++;
      else begin
        sbq.push_back({12'(k % ORB), texp[k % 512]});
        push = 1;
      end
    end
    pop = (occ != 0 && rdy) ? 1 : 0;
    occ = occ + push - pop;
    if (we) begin
      model[wa] = 3'(wd);
      known[wa] = 1'b1;
    end
    @(negedge clk);
    n++;
  endtask

  // Monitor: compares every entry leaving the FIFO against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      if (rd_valid && rd_ready) begin
        if (sbq.size() == 0) chk(1'b0, "R6", rd_bcid, -1);
        else begin
          logic [14:0] e;
          e = sbq.pop_front();
          chk(rd_mult == e[2:0], "R4", rd_mult, e[2:0]);
          chk(rd_bcid == e[14:3], "R3", rd_bcid, e[14:3]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin tkn[i] = 1'b0; tcol[i] = 1'b0; end
    for (int i = 0; i < 4096; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(trig_valid == 1'b0, "R8", trig_valid, 0);
    chk(rd_valid == 1'b0, "R8", rd_valid, 0);
    chk(busy == 1'b0, "R8", busy, 0);
    chk(drop_cnt == '0, "R8", drop_cnt, 0);
    rst_n = 1'b1;
    n = 0;
    // Table load; lookups of address 0 run meanwhile. Early accepts (R5).
    for (int i = 0; i < 4096; i++)
      step(0, 0, 1, i, pat(i),
           (i == 5) || (i == PD + 1) || (i >= PD + 3 && $urandom % 6 == 0),
           1, 0);
    // Streaming with collisions (R2) and readout back-pressure (R6).
    for (int i = 0; i < 700; i++) begin
      int a, t;
      bit acc;
      a = $urandom % 256;
      t = $urandom % 16;
      acc = ($urandom % 6 == 0);
      if ($urandom % 8 == 0) begin
        step(a, t, 1, (a << 4) | t, ~model[(a << 4) | t], acc, $urandom % 4 != 0, 1);
        step(a, t, 0, 0, 0, 0, 1, 1);
      end else begin
        step(a, t, 0, 0, 0, acc, $urandom % 4 != 0, 0);
      end
    end
    // Overflow burst: consumer stalled, accept every crossing (R7).
    for (int i = 0; i < 24; i++) step($urandom % 256, $urandom % 16, 0, 0, 0, 1, 0, 0);
    chk(busy == 1'b1, "R7", busy, 1);
    chk(edrop >= 8, "R7", edrop, 8);
    // Drain.
    for (int i = 0; i < 40; i++) step($urandom % 256, $urandom % 16, 0, 0, 0, 0, 1, 0);
    chk(sbq.size() == 0, "R6", sbq.size(), 0);
    chk(rd_valid == 1'b0, "R6", rd_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule